// File: doc/BRIEF.md
# Dequeue Response Ring Producer with Discrete Acknowledgment

This block is the hardware side of a 16-entry ring that carries dequeue responses to software. Each response taken from an input stream is written into the next ring slot together with a valid bit. The valid bit flips every time the producer index wraps, so software can tell fresh entries from stale ones. The block limits how many unconsumed entries may be outstanding. The limit comes from a configurable maximum fill.

Software reports consumption in one of three ways, chosen by a 2-bit mode. In the two index modes, software writes its new consumer index through either an uncached or a cached register port. In the discrete mode, software writes acknowledgment words that retire entries in any order, either one slot by index or any group of slots by mask. The consumer index only moves across an unbroken run of retired slots. A single-slot acknowledgment may also park the slot, which leaves a status bit set until that slot is written again.

The consumer index, the producer index and the resulting fill are always visible on outputs. After a mask acknowledgment, software reads back the consumer index and works out the fill as producer minus consumer, modulo 16.

Top module: `dq_ring_dca`

## Requirements
- R1: After reset the producer index, the consumer index and the fill are 0, all parked bits are 0, and the valid bit presented with writes is 1.
- R2: Each accepted input (in_valid and in_ready both high) writes slot `ring_idx`, which equals the producer index, and advances the producer index by one, wrapping from 15 to 0.
- R3: The valid bit presented with each write inverts on the edge at which the producer index wraps from 15 to 0. It is unchanged on every other edge.
- R4: in_ready is high exactly when the fill is below `cfg_maxfill`. A maximum fill of 0 stops production.
- R5: In mode 0, a write on `ci_wr` sets the consumer index only when (new − current) mod 16 does not exceed the fill. An out-of-window write is ignored, and so are writes on `ci_cwr`.
- R6: In mode 1, the cached port `ci_cwr` behaves as in R5, and writes on `ci_wr` are ignored.
- R7: In mode 2, an acknowledgment word with bit 8 = 0 retires the slot given in bits 3:0, with bit 6 as a park flag. With bit 8 = 1, it retires every slot i whose bit 16+i is set.
- R8: In mode 2, the consumer index advances, on the same edge as the acknowledgment, across the whole contiguous run of retired slots starting at it. It stops at the first unretired slot or at the producer index. Out-of-order retirements wait until the run reaches them.
- R9: An acknowledgment naming a slot that is not outstanding (its offset from the consumer index is not below the fill) is ignored and has no later effect.
- R10: A single-slot acknowledgment with the park flag on an outstanding slot sets that slot's parked bit. The bit clears when that slot is written again.
- R11: Acknowledgment writes are ignored in modes 0, 1 and 3. In mode 3 every consumption input is ignored.
- R12: When a write and a consumption happen on the same edge, both take effect, and the fill becomes the new producer index minus the new consumer index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Consumption mode: 0 uncached index, 1 cached index, 2 discrete acknowledgment, 3 none |
| cfg_maxfill | input | 4 | Maximum number of unconsumed slots |
| in_valid | input | 1 | Response available on the input stream |
| in_data | input | DW | Response payload |
| in_ready | output | 1 | Ring can accept a response |
| ring_we | output | 1 | Slot write strobe |
| ring_idx | output | 4 | Slot being written |
| ring_vbit | output | 1 | Valid bit placed in the slot's command byte |
| ring_data | output | DW | Payload written to the slot |
| ci_wr | input | 1 | Uncached consumer index write |
| ci_wdata | input | 4 | Value for the uncached write |
| ci_cwr | input | 1 | Cached consumer index write |
| ci_cwdata | input | 4 | Value for the cached write |
| dca_wr | input | 1 | Acknowledgment word write |
| dca_wdata | input | 32 | Acknowledgment word |
| prod_idx | output | 4 | Producer index |
| cons_idx | output | 4 | Consumer index |
| fill_cnt | output | 4 | Unconsumed slots, (prod − cons) mod 16 |
| parked | output | 16 | Parked status, one bit per slot |

## Verification
A slot write and a consumer-index advance can happen on the same edge. The bench provokes this by holding in_valid while it writes an acknowledgment that closes a run, and then checks that the producer index, the consumer index and the fill all moved together. A retirement and the run that it completes can also share an edge. Out-of-order single and mask acknowledgments followed by the missing one show whether the consumer index jumps over the whole run at once. A behavioural model of the ring judges each cycle, including long stretches of random stimulus in every mode.

// File: rtl/dqring_pkg.sv
package dqring_pkg;
   typedef enum logic [1:0] {
      CONS_IDX_UC   = 2'd0,
      CONS_IDX_CW   = 2'd1,
      CONS_DISCRETE = 2'd2,
      CONS_NONE     = 2'd3
   } cons_mode_e;

   localparam int ACK_W        = 32;
   localparam int ACK_FORM_BIT = 8;
   localparam int ACK_PARK_BIT = 6;
   localparam int ACK_MASK_LSB = 16;
endpackage

// File: rtl/dqring_producer.sv
module dqring_producer #(
   parameter int IW = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  push,
   output logic [IW-1:0]         pi,
   output logic                  vbit,
   output logic [(1<<IW)-1:0]    wr_onehot
);
   localparam int DEPTH = 1 << IW;
   localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pi   <= '0;
         vbit <= 1'b1;
      end else if (push) begin
         pi <= pi + 1'b1;
         if (pi == LAST) vbit <= ~vbit;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_wr
      assign wr_onehot[i] = push && (pi == IW'(i));
   end
endmodule

// File: rtl/dqring_ack_decode.sv
module dqring_ack_decode import dqring_pkg::*; #(
   parameter int IW = 4
) (
   input  logic                  en,
   input  logic [ACK_W-1:0]      word,
   input  logic [IW-1:0]         ci,
   input  logic [IW-1:0]         fill,
   output logic [(1<<IW)-1:0]    set_vec,
   output logic [(1<<IW)-1:0]    park_vec
);
   localparam int DEPTH = 1 << IW;

   logic          is_mask;
   logic          park_req;
   logic [IW-1:0] sel_idx;
   logic          unused_word_bits;

   assign is_mask          = word[ACK_FORM_BIT];
   assign park_req         = word[ACK_PARK_BIT];
   assign sel_idx          = word[IW-1:0];
   assign unused_word_bits = ^word;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [IW-1:0] offs;
      logic          outstanding;
      logic          hit_one;
      logic          hit_mask;
      assign offs        = IW'(i) - ci;
      assign outstanding = offs < fill;
      assign hit_one     = !is_mask && (sel_idx == IW'(i));
      assign hit_mask    = is_mask && word[ACK_MASK_LSB + i];
      assign set_vec[i]  = en && outstanding && (hit_one || hit_mask);
      assign park_vec[i] = en && outstanding && hit_one && park_req;
   end
endmodule

// File: rtl/dqring_cons_track.sv
module dqring_cons_track import dqring_pkg::*; #(
   parameter int IW = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  cons_mode_e            mode,
   input  logic                  ci_wr,
   input  logic [IW-1:0]         ci_wdata,
   input  logic                  ci_cwr,
   input  logic [IW-1:0]         ci_cwdata,
   input  logic [(1<<IW)-1:0]    set_vec,
   input  logic [(1<<IW)-1:0]    park_vec,
   input  logic [(1<<IW)-1:0]    wr_onehot,
   input  logic [IW-1:0]         fill,
   output logic [IW-1:0]         ci,
   output logic [(1<<IW)-1:0]    parked
);
   localparam int DEPTH = 1 << IW;

   logic [DEPTH-1:0] ret_q, ret_nx, ret_d, parked_d;
   logic [IW-1:0]    run, adv;
   logic             uc_ok, cw_ok;

   assign ret_nx = ret_q | set_vec;

   // length of the retired run starting at the consumer index
   always_comb begin
      logic stop;
      stop = 1'b0;
      run  = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (!stop && (IW'(k) < fill) && ret_nx[ci + IW'(k)]) run = run + 1'b1;
         else stop = 1'b1;
      end
   end

   assign uc_ok = (mode == CONS_IDX_UC) && ci_wr  && ((ci_wdata  - ci) <= fill);
   assign cw_ok = (mode == CONS_IDX_CW) && ci_cwr && ((ci_cwdata - ci) <= fill);

   always_comb begin
      adv = '0;
      if (mode == CONS_DISCRETE) adv = run;
      else if (uc_ok)            adv = ci_wdata - ci;
      else if (cw_ok)            adv = ci_cwdata - ci;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_flag
      logic [IW-1:0] offs;
      assign offs        = IW'(i) - ci;
      assign ret_d[i]    = ret_nx[i] && !(offs < adv);
      assign parked_d[i] = (parked[i] && !wr_onehot[i]) || park_vec[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ci     <= '0;
         ret_q  <= '0;
         parked <= '0;
      end else begin
         ci     <= ci + adv;
         ret_q  <= ret_d;
         parked <= parked_d;
      end
   end
endmodule

// File: rtl/dq_ring_dca.sv
module dq_ring_dca import dqring_pkg::*; #(
   parameter int IW = 4,
   parameter int DW = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            cfg_mode,
   input  logic [IW-1:0]         cfg_maxfill,
   input  logic                  in_valid,
   input  logic [DW-1:0]         in_data,
   output logic                  in_ready,
   output logic                  ring_we,
   output logic [IW-1:0]         ring_idx,
   output logic                  ring_vbit,
   output logic [DW-1:0]         ring_data,
   input  logic                  ci_wr,
   input  logic [IW-1:0]         ci_wdata,
   input  logic                  ci_cwr,
   input  logic [IW-1:0]         ci_cwdata,
   input  logic                  dca_wr,
   input  logic [ACK_W-1:0]      dca_wdata,
   output logic [IW-1:0]         prod_idx,
   output logic [IW-1:0]         cons_idx,
   output logic [IW-1:0]         fill_cnt,
   output logic [(1<<IW)-1:0]    parked
);
   localparam int DEPTH = 1 << IW;

   if (IW < 1 || IW > 4) begin : g_bad_iw
      $error("IW must lie in 1..4 so the mask field fits the acknowledgment word");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   cons_mode_e       mode;
   logic [IW-1:0]    pi, ci, fill;
   logic             vbit, push;
   logic [DEPTH-1:0] wr_onehot, set_vec, park_vec;

   assign mode     = cons_mode_e'(cfg_mode);
   assign fill     = pi - ci;
   assign in_ready = fill < cfg_maxfill;
   assign push     = in_valid && in_ready;

   dqring_producer #(.IW(IW)) u_prod (
      .clk(clk), .rst_n(rst_n), .push(push),
      .pi(pi), .vbit(vbit), .wr_onehot(wr_onehot)
   );

   dqring_ack_decode #(.IW(IW)) u_dec (
      .en(dca_wr && (mode == CONS_DISCRETE)), .word(dca_wdata),
      .ci(ci), .fill(fill), .set_vec(set_vec), .park_vec(park_vec)
   );

   dqring_cons_track #(.IW(IW)) u_cons (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .ci_wr(ci_wr), .ci_wdata(ci_wdata), .ci_cwr(ci_cwr), .ci_cwdata(ci_cwdata),
      .set_vec(set_vec), .park_vec(park_vec), .wr_onehot(wr_onehot),
      .fill(fill), .ci(ci), .parked(parked)
   );

   assign ring_we   = push;
   assign ring_idx  = pi;
   assign ring_vbit = vbit;
   assign ring_data = in_data;
   assign prod_idx  = pi;
   assign cons_idx  = ci;
   assign fill_cnt  = fill;
endmodule

// File: rtl/dq_ring_dca_chk.sv
module dq_ring_dca_chk #(
   parameter int IW = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          cfg_mode,
   input logic                dca_wr,
   input logic                ring_we,
   input logic [IW-1:0]       ring_idx,
   input logic                ring_vbit,
   input logic [IW-1:0]       prod_idx,
   input logic [IW-1:0]       cons_idx,
   input logic [IW-1:0]       fill_cnt,
   input logic [(1<<IW)-1:0]  parked
);
   localparam logic [IW-1:0] LAST = IW'((1 << IW) - 1);

   p_push_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ring_we |=> (prod_idx == IW'($past(prod_idx) + 1'b1)));

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ring_we |=> $stable(prod_idx));

   p_vbit_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_we && ring_idx == LAST) |=> (ring_vbit != $past(ring_vbit)));

   p_vbit_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ring_we && ring_idx == LAST) |=> $stable(ring_vbit));

   p_cons_within_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (IW'(cons_idx - $past(cons_idx)) <= $past(fill_cnt)));

   p_mode_none_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd3) |=> $stable(cons_idx));

   p_park_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(dca_wr && cfg_mode == 2'd2) |=> ($countones(parked) <= $countones($past(parked))));
endmodule

bind dq_ring_dca dq_ring_dca_chk #(.IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .dca_wr(dca_wr),
   .ring_we(ring_we), .ring_idx(ring_idx), .ring_vbit(ring_vbit),
   .prod_idx(prod_idx), .cons_idx(cons_idx), .fill_cnt(fill_cnt), .parked(parked)
);

// File: tb/dq_ring_dca_test.sv
module dq_ring_dca_test;
   localparam int IW = 4;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cfg_mode = 2'd2;
   logic [IW-1:0] cfg_maxfill = 4'd15;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_ready, ring_we, ring_vbit;
   logic [IW-1:0] ring_idx, prod_idx, cons_idx, fill_cnt;
   logic [DW-1:0] ring_data;
   logic          ci_wr = 1'b0, ci_cwr = 1'b0, dca_wr = 1'b0;
   logic [IW-1:0] ci_wdata = '0, ci_cwdata = '0;
   logic [31:0]   dca_wdata = '0;
   logic [15:0]   parked;

   always #10 clk = ~clk;

   dq_ring_dca #(.IW(IW), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_maxfill(cfg_maxfill),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .ring_we(ring_we), .ring_idx(ring_idx), .ring_vbit(ring_vbit), .ring_data(ring_data),
      .ci_wr(ci_wr), .ci_wdata(ci_wdata), .ci_cwr(ci_cwr), .ci_cwdata(ci_cwdata),
      .dca_wr(dca_wr), .dca_wdata(dca_wdata),
      .prod_idx(prod_idx), .cons_idx(cons_idx), .fill_cnt(fill_cnt), .parked(parked)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   // behavioural reference state
   int        m_pi, m_ci;
   bit        m_vb;
   bit [15:0] m_ret, m_park;

   function automatic int mfill();
      return (m_pi - m_ci) & 15;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_step();
      int f, nci, k, adv, idx;
      bit we;
      if (!rst_n) begin
         m_pi = 0; m_ci = 0; m_vb = 1; m_ret = '0; m_park = '0;
         return;
      end
      f   = mfill();
      we  = in_valid && (f < int'(cfg_maxfill));
      nci = m_ci;
      if (cfg_mode == 2'd2 && dca_wr) begin
         if (dca_wdata[8]) begin
            for (int i = 0; i < 16; i++)
               if (dca_wdata[16+i] && (((i - m_ci) & 15) < f)) m_ret[i] = 1'b1;
         end else begin
            idx = int'(dca_wdata[3:0]);
            if (((idx - m_ci) & 15) < f) begin
               m_ret[idx] = 1'b1;
               if (dca_wdata[6]) m_park[idx] = 1'b1;
            end
         end
      end
      if (cfg_mode == 2'd2) begin
         k = 0;
         while (k < f && m_ret[(m_ci + k) & 15]) k++;
         nci = (m_ci + k) & 15;
      end else if (cfg_mode == 2'd0 && ci_wr && (((int'(ci_wdata) - m_ci) & 15) <= f)) begin
         nci = int'(ci_wdata);
      end else if (cfg_mode == 2'd1 && ci_cwr && (((int'(ci_cwdata) - m_ci) & 15) <= f)) begin
         nci = int'(ci_cwdata);
      end
      adv = (nci - m_ci) & 15;
      for (int j = 0; j < adv; j++) m_ret[(m_ci + j) & 15] = 1'b0;
      if (we) begin
         m_park[m_pi] = 1'b0;
         if (m_pi == 15) m_vb = ~m_vb;
         m_pi = (m_pi + 1) & 15;
      end
      m_ci = nci;
   endtask

   task automatic compare_all();
      chk("R2 prod_idx", int'(prod_idx), m_pi);
      chk("R2 ring_idx", int'(ring_idx), m_pi);
      chk("R3 ring_vbit", int'(ring_vbit), int'(m_vb));
      chk("R8 cons_idx", int'(cons_idx), m_ci);
      chk("R12 fill_cnt", int'(fill_cnt), mfill());
      chk("R4 in_ready", int'(in_ready), int'(mfill() < int'(cfg_maxfill)));
      chk("R10 parked", int'(parked), int'(m_park));
      if (ring_we) chk("R2 ring_data", int'(ring_data), int'(in_data));
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic ack_one(int idx, bit park);
      dca_wdata = 32'(idx & 15) | (park ? 32'h40 : 32'h0);
      dca_wr = 1'b1;
      tick();
      dca_wr = 1'b0;
   endtask

   task automatic ack_mask(bit [15:0] mask);
      dca_wdata = {mask, 16'h0100};
      dca_wr = 1'b1;
      tick();
      dca_wr = 1'b0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 prod_idx", int'(prod_idx), 0);
      chk("R1 cons_idx", int'(cons_idx), 0);
      chk("R1 fill_cnt", int'(fill_cnt), 0);
      chk("R1 parked", int'(parked), 0);
      chk("R1 ring_vbit", int'(ring_vbit), 1);

      // fill up to the limit of 15
      in_valid = 1'b1;
      for (int i = 0; i < 18; i++) begin
         in_data = DW'(16'hA000 + i);
         tick();
      end
      in_valid = 1'b0;
      chk("R2 prod after burst", int'(prod_idx), 15);
      chk("R4 in_ready at max fill", int'(in_ready), 0);
      chk("R3 vbit before wrap", int'(ring_vbit), 1);

      // out-of-order discrete acknowledgments
      ack_one(2, 0);
      chk("R8 out of order held", int'(cons_idx), 0);
      ack_one(0, 0);
      chk("R8 single advance", int'(cons_idx), 1);
      ack_one(1, 0);
      chk("R8 run closes", int'(cons_idx), 3);
      ack_mask(16'h00F0);
      chk("R7 mask held", int'(cons_idx), 3);
      ack_one(3, 0);
      chk("R7 mask run", int'(cons_idx), 8);
      ack_one(8, 1);
      chk("R10 park set", int'(parked), 16'h0100);
      chk("R10 park retires", int'(cons_idx), 9);

      // index modes
      cfg_mode = 2'd0;
      ack_one(9, 0);
      chk("R11 ack ignored mode 0", int'(cons_idx), 9);
      ci_cwdata = 4'd12; ci_cwr = 1'b1; tick(); ci_cwr = 1'b0;
      chk("R5 cached port ignored", int'(cons_idx), 9);
      ci_wdata = 4'd12; ci_wr = 1'b1; tick(); ci_wr = 1'b0;
      chk("R5 uncached write", int'(cons_idx), 12);
      ci_wdata = 4'd3; ci_wr = 1'b1; tick(); ci_wr = 1'b0;
      chk("R5 out of window", int'(cons_idx), 12);
      cfg_mode = 2'd1;
      ci_wdata = 4'd14; ci_wr = 1'b1; tick(); ci_wr = 1'b0;
      chk("R6 uncached ignored", int'(cons_idx), 12);
      ci_cwdata = 4'd14; ci_cwr = 1'b1; tick(); ci_cwr = 1'b0;
      chk("R6 cached write", int'(cons_idx), 14);
      cfg_mode = 2'd3;
      ci_wdata = 4'd15; ci_cwdata = 4'd15; ci_wr = 1'b1; ci_cwr = 1'b1;
      tick();
      ci_wr = 1'b0; ci_cwr = 1'b0;
      ack_one(14, 0);
      chk("R11 mode 3 ignores all", int'(cons_idx), 14);

      // back to discrete, ack of a slot not outstanding
      cfg_mode = 2'd2;
      ack_one(14, 0);
      chk("R8 drained", int'(fill_cnt), 0);
      ack_one(0, 0);
      in_valid = 1'b1;
      tick(); tick();
      in_valid = 1'b0;
      chk("R3 vbit after wrap", int'(ring_vbit), 0);
      chk("R2 prod wrapped", int'(prod_idx), 1);
      ack_one(15, 0);
      chk("R9 stale ack dropped", int'(cons_idx), 0);

      // rewrite slot 8 clears its parked bit
      in_valid = 1'b1;
      for (int i = 0; i < 8; i++) tick();
      chk("R10 park cleared", int'(parked), 0);
      // write and retire on the same edge
      dca_wdata = 32'h0; dca_wr = 1'b1;
      tick();
      dca_wr = 1'b0; in_valid = 1'b0;
      chk("R12 prod same edge", int'(prod_idx), 10);
      chk("R12 cons same edge", int'(cons_idx), 1);
      chk("R12 fill same edge", int'(fill_cnt), 9);

      cfg_maxfill = 4'd0;
      in_valid = 1'b1;
      #1;
      chk("R4 zero max fill", int'(in_ready), 0);
      tick();
      in_valid = 1'b0;
      chk("R4 no write at zero", int'(prod_idx), 10);

      // random stretches in every mode
      for (int seg = 0; seg < 6; seg++) begin
         cfg_mode = (seg == 5) ? 2'd2 : 2'(seg % 4);
         cfg_maxfill = 4'(3 + ($urandom % 13));
         for (int c = 0; c < 150; c++) begin
            in_valid  = ($urandom % 2) == 0;
            in_data   = DW'($urandom);
            dca_wr    = ($urandom % 3) == 0;
            dca_wdata = $urandom;
            ci_wr     = ($urandom % 3) == 0;
            ci_wdata  = 4'(m_ci + ($urandom % (mfill() + 3)));
            ci_cwr    = ($urandom % 3) == 0;
            ci_cwdata = 4'(m_ci + ($urandom % (mfill() + 3)));
            tick();
         end
      end
      summary();
   end
endmodule